// File: doc/BRIEF.md
# Data-Side Translation Fault Recorder

This block holds the record of the most recent translation fault seen by a data-side memory management unit. The translation logic raises a single-cycle fault pulse. With the pulse it supplies the virtual address that faulted, a flag for user-mode accesses, a flag for writes, and a small cause field. The block folds these into a status word and keeps the faulting address in a separate register. Software reads both through a small register port and acknowledges a fault by writing the status word.

If a second fault arrives before software has acknowledged the first, the old record is dropped. The status keeps only an overflow marker, and the new fault's bits are merged on top of it, so software can tell that at least one fault was lost. Writing the status word with its valid bit clear wipes both registers. Writing it with the valid bit set stores the written value as it stands. A hardware fault always wins over a software write in the same cycle.

Top module: `dmmu_fault_recorder`

## Requirements
- R1: After reset, both the status word and the fault address register read as zero.
- R2: A fault pulse while status bit 0 is clear leaves a status word made of bit 0 set, bit 2 equal to the write flag, bit 3 equal to the user flag, and the cause field at bits 7 upward. Every other bit is zero.
- R3: A fault pulse while status bit 0 is set first reduces the status to the value 2 (only bit 1, the overflow flag, set). It then ORs in the new fault's bits as in R2, so the earlier fault's user, write and cause bits are lost.
- R4: Every fault pulse loads the fault address register with the faulting address. After several faults the register holds the last one.
- R5: A software write to the status select (regSel = 0) with data bit 0 equal to zero clears both the status word and the fault address register.
- R6: A software write to the status select with data bit 0 equal to one stores the written value verbatim in the status word and leaves the fault address register unchanged.
- R7: When a fault pulse and a software status write fall in the same cycle, the fault is recorded as in R2 to R4 and the software write has no effect.
- R8: A software write to the address select (regSel = 1) changes neither register.
- R9: The read data shows the status word zero-extended when regSel = 0, and the fault address register when regSel = 1.
- R10: The lowest bit of the cause field, at status bit 7, carries the privilege-violation indication supplied with the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultPulse | input | 1 | One-cycle strobe: record a fault this cycle |
| faultAddr | input | VA_W | Virtual address of the faulting access |
| faultUser | input | 1 | Faulting access came from user mode |
| faultWrite | input | 1 | Faulting access was a write |
| faultType | input | TYPE_W | Cause field; bit 0 means privilege violation |
| regWrEn | input | 1 | Software register write strobe |
| regSel | input | 1 | Register select: 0 status word, 1 fault address |
| regWrData | input | STAT_W | Software write data |
| regRdData | output | VA_W | Read data of the selected register |

## Verification
The bench builds the block with VA_W = 48, STAT_W = 16 and TYPE_W = 5. With these values the cause field spans bits 7 to 11 and the status word has spare upper bits. That lets a verbatim software load place ones outside every hardware-owned field, and shows that the overflow collapse discards them. The 48-bit address is wider than the status word, which puts the zero-extension of the status read and the full-width address capture within reach. A scripted run of back-to-back faults, clears and same-cycle collisions is followed by a long random mix of all operations, with each result checked against a model.

// File: rtl/dmmu_fault_pkg.sv
package dmmu_fault_pkg;

  // Status word bit positions; software decodes these
  localparam int VALID_BIT = 0;
  localparam int OVF_BIT   = 1;
  localparam int WRITE_BIT = 2;
  localparam int USER_BIT  = 3;
  localparam int TYPE_LSB  = 7;

  // Register select encodings
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ADDR   = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // record a hardware fault
    logic swLoad;   // software stores the status word verbatim
    logic swClear;  // software wipes both registers
  } fsrStrobes_t;

endpackage

// File: rtl/dmmu_fault_ctrl.sv
module dmmu_fault_ctrl
  import dmmu_fault_pkg::*;
(
  input  logic        faultPulse,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic        wrValidBit,
  output fsrStrobes_t strb
);

  logic swStatusWr;

  always_comb begin
    // a write to the address select is dropped here
    swStatusWr   = regWrEn && (regSel == SEL_STATUS);
    strb.capture = faultPulse;
    // hardware fault has priority over any software access
    strb.swLoad  = swStatusWr && wrValidBit  && !faultPulse;
    strb.swClear = swStatusWr && !wrValidBit && !faultPulse;
  end

endmodule

// File: rtl/dmmu_fault_datapath.sv
module dmmu_fault_datapath
  import dmmu_fault_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int STAT_W = 16,
  parameter int TYPE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsrStrobes_t       strb,
  input  logic [VA_W-1:0]   faultAddr,
  input  logic              faultUser,
  input  logic              faultWrite,
  input  logic [TYPE_W-1:0] faultType,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statusQ,
  output logic [VA_W-1:0]   addrQ
);

  localparam logic [STAT_W-1:0] OVF_WORD = STAT_W'(1) << OVF_BIT;

  logic [STAT_W-1:0] baseWord;
  logic [STAT_W-1:0] causeWord;
  logic [STAT_W-1:0] faultWord;

  always_comb begin
    // an unacknowledged record collapses to the overflow marker
    baseWord  = statusQ[VALID_BIT] ? OVF_WORD : statusQ;
    causeWord = '0;
    causeWord[VALID_BIT]            = 1'b1;
    causeWord[WRITE_BIT]            = faultWrite;
    causeWord[USER_BIT]             = faultUser;
    causeWord[TYPE_LSB +: TYPE_W]   = faultType;
    faultWord = baseWord | causeWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (strb.capture) begin
      statusQ <= faultWord;
    end else if (strb.swClear) begin
      statusQ <= '0;
    end else if (strb.swLoad) begin
      statusQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strb.capture) begin
      addrQ <= faultAddr;
    end else if (strb.swClear) begin
      addrQ <= '0;
    end
  end

endmodule

// File: rtl/dmmu_fault_rdmux.sv
module dmmu_fault_rdmux
  import dmmu_fault_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int STAT_W = 16
) (
  input  logic              regSel,
  input  logic [STAT_W-1:0] statusQ,
  input  logic [VA_W-1:0]   addrQ,
  output logic [VA_W-1:0]   rdData
);

  always_comb begin
    rdData = '0;
    if (regSel == SEL_ADDR) begin
      rdData = addrQ;
    end else begin
      rdData[STAT_W-1:0] = statusQ;
    end
  end

endmodule

// File: rtl/dmmu_fault_recorder.sv
module dmmu_fault_recorder
  import dmmu_fault_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int STAT_W = 16,
  parameter int TYPE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultPulse,
  input  logic [VA_W-1:0]   faultAddr,
  input  logic              faultUser,
  input  logic              faultWrite,
  input  logic [TYPE_W-1:0] faultType,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [STAT_W-1:0] regWrData,
  output logic [VA_W-1:0]   regRdData
);

  fsrStrobes_t       strb;
  logic [STAT_W-1:0] statusQ;
  logic [VA_W-1:0]   addrQ;

  dmmu_fault_ctrl u_ctrl (
    .faultPulse (faultPulse),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .wrValidBit (regWrData[VALID_BIT]),
    .strb       (strb)
  );

  dmmu_fault_datapath #(
    .VA_W   (VA_W),
    .STAT_W (STAT_W),
    .TYPE_W (TYPE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .faultAddr  (faultAddr),
    .faultUser  (faultUser),
    .faultWrite (faultWrite),
    .faultType  (faultType),
    .wrData     (regWrData),
    .statusQ    (statusQ),
    .addrQ      (addrQ)
  );

  dmmu_fault_rdmux #(
    .VA_W   (VA_W),
    .STAT_W (STAT_W)
  ) u_rd (
    .regSel  (regSel),
    .statusQ (statusQ),
    .addrQ   (addrQ),
    .rdData  (regRdData)
  );

endmodule

// File: rtl/dmmu_fault_recorder_chk.sv
module dmmu_fault_recorder_chk
  import dmmu_fault_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              faultPulse,
  input logic [VA_W-1:0]   faultAddr,
  input logic              regWrEn,
  input logic              regSel,
  input logic [STAT_W-1:0] regWrData,
  input logic [STAT_W-1:0] statusQ,
  input logic [VA_W-1:0]   addrQ
);

  logic swClr;
  assign swClr = regWrEn && (regSel == SEL_STATUS) && !regWrData[VALID_BIT];

  // R2: any recorded fault leaves the valid bit set
  p_fault_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> statusQ[VALID_BIT]);

  // R3: a fault on top of a live record raises overflow
  p_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (faultPulse && statusQ[VALID_BIT]) |=> statusQ[OVF_BIT]);

  // R2: a fault on a clean record never shows overflow
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (faultPulse && !statusQ[VALID_BIT]) |=> !statusQ[OVF_BIT]);

  // R4: address of the fault is captured
  p_addr_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |=> (addrQ == $past(faultAddr)));

  // R5: software clear wipes both registers
  p_sw_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swClr && !faultPulse) |=> (statusQ == '0 && addrQ == '0));

  // R1, R5: a record without valid bit is always empty
  p_invalid_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    !statusQ[VALID_BIT] |-> (statusQ == '0));

  // R8: only faults and clears move the address register
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!faultPulse && !swClr) |=> $stable(addrQ));

endmodule

bind dmmu_fault_recorder dmmu_fault_recorder_chk #(
  .VA_W   (VA_W),
  .STAT_W (STAT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .faultPulse (faultPulse),
  .faultAddr  (faultAddr),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .regWrData  (regWrData),
  .statusQ    (statusQ),
  .addrQ      (addrQ)
);

// File: tb/dmmu_fault_recorder_tb.sv
`timescale 1ns/1ps
module dmmu_fault_recorder_tb;

  localparam int VA_W   = 48;
  localparam int STAT_W = 16;
  localparam int TYPE_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              faultPulse = 1'b0;
  logic [VA_W-1:0]   faultAddr = '0;
  logic              faultUser = 1'b0;
  logic              faultWrite = 1'b0;
  logic [TYPE_W-1:0] faultType = '0;
  logic              regWrEn = 1'b0;
  logic              regSel = 1'b0;
  logic [STAT_W-1:0] regWrData = '0;
  logic [VA_W-1:0]   regRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rdPending = 1'b0;

  logic [VA_W-1:0] expQ[$];
  string           tagQ[$];

  logic [STAT_W-1:0] mStat = '0;
  logic [VA_W-1:0]   mAddr = '0;

  always #4 clk = ~clk;

  dmmu_fault_recorder #(
    .VA_W   (VA_W),
    .STAT_W (STAT_W),
    .TYPE_W (TYPE_W)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .faultPulse (faultPulse),
    .faultAddr  (faultAddr),
    .faultUser  (faultUser),
    .faultWrite (faultWrite),
    .faultType  (faultType),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .regRdData  (regRdData)
  );

  // Model of R2/R3/R10
  function automatic logic [STAT_W-1:0] faultModel(logic [STAT_W-1:0] s, logic u,
                                                  logic w, logic [TYPE_W-1:0] t);
    logic [STAT_W-1:0] r;
    r = s[0] ? STAT_W'(2) : s;
    r[0] = 1'b1;
    r[2] = r[2] | w;
    r[3] = r[3] | u;
    r[7 +: TYPE_W] = r[7 +: TYPE_W] | t;
    return r;
  endfunction

  task automatic quiet();
    faultPulse = 1'b0;
    regWrEn    = 1'b0;
    rdPending  = 1'b0;
  endtask

  task automatic doFault(logic [VA_W-1:0] a, logic u, logic w, logic [TYPE_W-1:0] t,
                         logic swEn, logic [STAT_W-1:0] swData);
    @(posedge clk); #1;
    quiet();
    faultPulse = 1'b1; faultAddr = a; faultUser = u; faultWrite = w; faultType = t;
    regWrEn = swEn; regSel = 1'b0; regWrData = swData;
    mStat = faultModel(mStat, u, w, t);   // R7: software part ignored
    mAddr = a;
  endtask

  task automatic doWrite(logic sel, logic [STAT_W-1:0] d);
    @(posedge clk); #1;
    quiet();
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    if (sel == 1'b0) begin
      if (d[0]) mStat = d;
      else begin mStat = '0; mAddr = '0; end
    end
  endtask

  task automatic doRead(logic sel, string tag);
    logic [VA_W-1:0] e;
    @(posedge clk); #1;
    quiet();
    regSel = sel;
    e = '0;
    if (sel) e = mAddr; else e[STAT_W-1:0] = mStat;
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdPending = 1'b1;
  endtask

  task automatic readBoth(string tS, string tA);
    doRead(1'b0, tS);
    doRead(1'b1, tA);
  endtask

  // Monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rdPending && expQ.size() > 0) begin
      logic [VA_W-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (regRdData !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, regRdData, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    readBoth("R1 status after reset", "R1 address after reset");

    // R2, R10: clean fault, user + privilege cause
    doFault(48'h1234_5678_A000, 1'b1, 1'b0, 5'b00001, 1'b0, '0);
    readBoth("R2 R10 clean fault status", "R4 first fault address");

    // R3: second fault before acknowledge
    doFault(48'h0000_BEEF_C000, 1'b0, 1'b1, 5'b00010, 1'b0, '0);
    readBoth("R3 overflow status", "R4 last fault address");

    // R3: third fault keeps only overflow plus newest bits
    doFault(48'h7FFF_0000_2000, 1'b0, 1'b0, 5'b10000, 1'b0, '0);
    doRead(1'b0, "R3 repeated overflow status");

    // R5: software clear with bit0 zero, other bits set
    doWrite(1'b0, 16'hF1F0);
    readBoth("R5 status cleared", "R5 address cleared");

    // R2: clean fault after clear, write only
    doFault(48'h0000_0000_6000, 1'b0, 1'b1, 5'b00000, 1'b0, '0);
    doRead(1'b0, "R2 write fault status");

    // R8: write to address select ignored
    doWrite(1'b1, 16'hDEAD);
    readBoth("R8 status unchanged", "R8 address unchanged");

    // R6: verbatim load with bit0 set, address untouched
    doWrite(1'b0, 16'hF0C3);
    readBoth("R6 status loaded", "R6 address kept");

    // R3: fault on a software-loaded record drops upper bits
    doFault(48'h0000_0001_0000, 1'b1, 1'b1, 5'b00100, 1'b0, '0);
    doRead(1'b0, "R3 overflow over loaded word");

    // R5 then R7: fault and software clear in the same cycle
    doWrite(1'b0, 16'h0000);
    doFault(48'h0000_2222_4000, 1'b1, 1'b0, 5'b01001, 1'b1, 16'h0000);
    readBoth("R7 fault beats clear status", "R7 fault beats clear address");

    // R7: fault and software load in the same cycle
    doFault(48'h0000_3333_8000, 1'b0, 1'b0, 5'b00011, 1'b1, 16'hAAAB);
    readBoth("R7 fault beats load status", "R7 fault beats load address");

    // Random mix of every operation
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0, 1: doFault({$urandom, $urandom} & {VA_W{1'b1}} , 1'($urandom), 1'($urandom),
                      TYPE_W'($urandom), 1'($urandom), STAT_W'($urandom));
        2: doWrite(1'b0, STAT_W'($urandom));
        3: doWrite(1'b0, STAT_W'($urandom) & ~STAT_W'(1));
        default: doWrite(1'b1, STAT_W'($urandom));
      endcase
      readBoth("R9 random status read", "R9 random address read");
    end

    @(posedge clk); #1;
    quiet();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule